// File: doc/BRIEF.md
# Match-Driven Debug State Sequencer

This block sits behind four debug comparators and decides when a debug trigger fires. It walks through three working states (State1, State2, State3) and a terminal Final state. Each working state owns a 4-bit select code. The code chooses which comparator matches move the sequencer and to which state each one goes. A match on a comparator counts only when that comparator's enable bit is set.

Software first loads the three select codes while the sequencer is disarmed. A write lands only when the page qualifier carries the value 01. Raising the arm level starts the walk in State1. When the walk reaches Final, a sticky trigger output is raised and the state freezes until the arm level drops. Dropping the arm level returns the block to idle. When several matches arrive in one cycle, the lowest-numbered effective channel wins, but any match that leads to Final beats all the others.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `trig_o` is 0, and all three select codes are 0000. Code 0000 is reserved, so an armed sequencer left at reset codes stays in State1 whatever the matches.
- R2: The state encoding is idle=0, State1=1, State2=2, State3=3, Final=4. With `arm_i` high in idle, the next edge enters State1. With `arm_i` low, the next edge returns to idle from any state and clears `trig_o`. Matches have no effect in idle.
- R3: A match on channel c is ignored unless `match_en_i[c]` is 1 in the same cycle.
- R4: In State1 the codes act as follows, and any channel not listed has no effect. 0001: m0→S2. 0010: m1→S3. 0011: m2→S2. 0100: m3→Final. 0101: m0→S2 and m1→S3. 0110: m0→S2 and m2→S3. 0111: m1→S2 and m3→S3. 1000: m3→S3 and m1→Final. 1001: m1→S3 and m0→Final. 1010: m2→S3 and m0→Final. 1011: any match→Final.
- R5: In State2 the codes act as follows. 0001: m0→S1. 0010: m2→S3. 0011: m2→Final. 0100: m0, m1 and m2→S3, with m3 ignored. 0101: m1→S1 and m3→Final. 0110: any match→Final.
- R6: In State3 the codes act as follows. 0001: m0→S1. 0010: m1→S2. 0011: m3→Final. 0100: any match→S1. 0101: m2→S2 and m0→Final.
- R7: Any code not listed for a state is reserved. With a reserved code, the state does not change for any combination of matches.
- R8: Among simultaneous effective matches, the lowest-numbered channel picks the next state.
- R9: If any effective match leads to Final, the sequencer goes to Final, even when a lower-numbered channel targets another state.
- R10: In Final with `arm_i` high, `trig_o` stays 1 and the state stays 4 whatever the matches.
- R11: A write takes effect only when `wr_en_i` is 1, `wr_page_i` is 01 and `arm_i` is 0. `wr_sel_i` picks the code: 0 for State1, 1 for State2, 2 for State3, and 3 writes nothing. All other writes are ignored.
- R12: A qualifying match sampled at a clock edge changes `state_o` at that same edge. The sequencer makes at most one transition per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm level; high runs the sequencer |
| match_i | input | 4 | Comparator match pulses, channel 0 in bit 0 |
| match_en_i | input | 4 | Per-comparator enable |
| wr_en_i | input | 1 | Select-code write strobe |
| wr_page_i | input | 2 | Page qualifier; writes need 01 |
| wr_sel_i | input | 2 | Which state's select code to write |
| wr_data_i | input | 4 | Select-code value |
| state_o | output | 3 | Current state (idle 0, S1 1, S2 2, S3 3, Final 4) |
| trig_o | output | 1 | Sticky trigger, high while in Final |

## Verification
The assertions take the arm level to be a synchronous input that holds for whole cycles. They also take matches to be sampled only at the clock edge, so a pulse that falls between edges is never seen. The stimulus changes every input on the falling edge only, and it keeps `arm_i` low across every cycle in which it loads a select code, except in the cycles that test a write made while armed. The frozen-code check reads the internal code bank through the bind, so it rests only on the arm level seen at each edge.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int unsigned NCH    = 4;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned PAGE_W = 2;
    localparam int unsigned NSEL   = 3;
    localparam int unsigned SEL_W  = $clog2(NSEL + 1);
    localparam int unsigned ST_W   = 3;
    localparam int unsigned CH_W   = $clog2(NCH);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FINAL = 3'd4
    } seq_st_e;

    typedef enum logic [2:0] {
        TG_NONE  = 3'd0,
        TG_ONE   = 3'd1,
        TG_TWO   = 3'd2,
        TG_THREE = 3'd3,
        TG_FINAL = 3'd4
    } tgt_e;

    typedef struct packed {
        seq_st_e st;
        logic    trig;
    } seq_s;

    // State1 steering table
    function automatic tgt_e one_tgt(logic [CODE_W-1:0] code, logic [CH_W-1:0] ch);
        tgt_e t;
        t = TG_NONE;
        case (code)
            4'd1:  if (ch == 2'd0) t = TG_TWO;
            4'd2:  if (ch == 2'd1) t = TG_THREE;
            4'd3:  if (ch == 2'd2) t = TG_TWO;
            4'd4:  if (ch == 2'd3) t = TG_FINAL;
            4'd5:  begin
                       if (ch == 2'd0) t = TG_TWO;
                       if (ch == 2'd1) t = TG_THREE;
                   end
            4'd6:  begin
                       if (ch == 2'd0) t = TG_TWO;
                       if (ch == 2'd2) t = TG_THREE;
                   end
            4'd7:  begin
                       if (ch == 2'd1) t = TG_TWO;
                       if (ch == 2'd3) t = TG_THREE;
                   end
            4'd8:  begin
                       if (ch == 2'd3) t = TG_THREE;
                       if (ch == 2'd1) t = TG_FINAL;
                   end
            4'd9:  begin
                       if (ch == 2'd1) t = TG_THREE;
                       if (ch == 2'd0) t = TG_FINAL;
                   end
            4'd10: begin
                       if (ch == 2'd2) t = TG_THREE;
                       if (ch == 2'd0) t = TG_FINAL;
                   end
            4'd11: t = TG_FINAL;
            default: t = TG_NONE;
        endcase
        return t;
    endfunction

    // State2 steering table
    function automatic tgt_e two_tgt(logic [CODE_W-1:0] code, logic [CH_W-1:0] ch);
        tgt_e t;
        t = TG_NONE;
        case (code)
            4'd1: if (ch == 2'd0) t = TG_ONE;
            4'd2: if (ch == 2'd2) t = TG_THREE;
            4'd3: if (ch == 2'd2) t = TG_FINAL;
            4'd4: if (ch != 2'd3) t = TG_THREE;
            4'd5: begin
                      if (ch == 2'd1) t = TG_ONE;
                      if (ch == 2'd3) t = TG_FINAL;
                  end
            4'd6: t = TG_FINAL;
            default: t = TG_NONE;
        endcase
        return t;
    endfunction

    // State3 steering table
    function automatic tgt_e three_tgt(logic [CODE_W-1:0] code, logic [CH_W-1:0] ch);
        tgt_e t;
        t = TG_NONE;
        case (code)
            4'd1: if (ch == 2'd0) t = TG_ONE;
            4'd2: if (ch == 2'd1) t = TG_TWO;
            4'd3: if (ch == 2'd3) t = TG_FINAL;
            4'd4: t = TG_ONE;
            4'd5: begin
                      if (ch == 2'd2) t = TG_TWO;
                      if (ch == 2'd0) t = TG_FINAL;
                  end
            default: t = TG_NONE;
        endcase
        return t;
    endfunction

    function automatic seq_st_e tgt_to_st(tgt_e t);
        seq_st_e s;
        case (t)
            TG_ONE:   s = ST_ONE;
            TG_TWO:   s = ST_TWO;
            TG_THREE: s = ST_THREE;
            TG_FINAL: s = ST_FINAL;
            default:  s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dbgseq_regs.sv
module dbgseq_regs
    import dbgseq_pkg::*;
#(
    parameter int unsigned    N_SEL   = NSEL,
    parameter int unsigned    C_W     = CODE_W,
    parameter int unsigned    P_W     = PAGE_W,
    parameter logic [P_W-1:0] PAGE_OK = 2'b01
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        armed,
    input  logic                        wr_en,
    input  logic [P_W-1:0]              wr_page,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [C_W-1:0]              wr_data,
    output logic [N_SEL-1:0][C_W-1:0]   codes
);

    logic                      wr_ok;
    logic [N_SEL-1:0][C_W-1:0] code_d, code_q;

    assign wr_ok = wr_en && (wr_page == PAGE_OK) && !armed;

    for (genvar g = 0; g < N_SEL; g++) begin : g_code
        always_comb begin
            code_d[g] = code_q[g];
            if (wr_ok && (wr_sel == SEL_W'(g))) begin
                code_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_q[g] <= '0;
            else        code_q[g] <= code_d[g];
        end
    end

    assign codes = code_q;

endmodule

// File: rtl/dbgseq_decode.sv
module dbgseq_decode
    import dbgseq_pkg::*;
(
    input  seq_st_e                      state,
    input  logic [NSEL-1:0][CODE_W-1:0]  codes,
    input  logic [NCH-1:0]               match,
    input  logic [NCH-1:0]               match_en,
    output tgt_e                         tgt [NCH]
);

    logic [NCH-1:0] qual;

    assign qual = match & match_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            tgt[c] = TG_NONE;
            if (qual[c]) begin
                case (state)
                    ST_ONE:   tgt[c] = one_tgt(codes[0], CH_W'(c));
                    ST_TWO:   tgt[c] = two_tgt(codes[1], CH_W'(c));
                    ST_THREE: tgt[c] = three_tgt(codes[2], CH_W'(c));
                    default:  tgt[c] = TG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dbgseq_arb.sv
module dbgseq_arb
    import dbgseq_pkg::*;
(
    input  tgt_e  tgt [NCH],
    output logic  hit,
    output tgt_e  win
);

    logic [NCH-1:0] to_final;
    logic [NCH-1:0] live;

    for (genvar c = 0; c < NCH; c++) begin : g_flag
        assign to_final[c] = (tgt[c] == TG_FINAL);
        assign live[c]     = (tgt[c] != TG_NONE);
    end

    always_comb begin
        win = TG_NONE;
        // walk downward so the lowest live channel is the last to write
        for (int c = NCH - 1; c >= 0; c--) begin
            if (live[c]) win = tgt[c];
        end
        if (|to_final) win = TG_FINAL;
        hit = |live;
    end

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
    import dbgseq_pkg::*;
#(
    parameter logic [PAGE_W-1:0] PAGE_OK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [NCH-1:0]    match_i,
    input  logic [NCH-1:0]    match_en_i,
    input  logic              wr_en_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [CODE_W-1:0] wr_data_i,
    output logic [ST_W-1:0]   state_o,
    output logic              trig_o
);

    logic [NSEL-1:0][CODE_W-1:0] sel_q;
    tgt_e                        ch_tgt [NCH];
    logic                        hit;
    tgt_e                        win;
    seq_s                        s_d, s_q;

    dbgseq_regs #(
        .N_SEL   (NSEL),
        .C_W     (CODE_W),
        .P_W     (PAGE_W),
        .PAGE_OK (PAGE_OK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (arm_i),
        .wr_en   (wr_en_i),
        .wr_page (wr_page_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .codes   (sel_q)
    );

    dbgseq_decode u_dec (
        .state    (s_q.st),
        .codes    (sel_q),
        .match    (match_i),
        .match_en (match_en_i),
        .tgt      (ch_tgt)
    );

    dbgseq_arb u_arb (
        .tgt (ch_tgt),
        .hit (hit),
        .win (win)
    );

    always_comb begin
        s_d = s_q;
        if (!arm_i) begin
            s_d.st   = ST_IDLE;
            s_d.trig = 1'b0;
        end else begin
            case (s_q.st)
                ST_IDLE:  s_d.st = ST_ONE;
                ST_FINAL: s_d.st = ST_FINAL;
                default: begin
                    if (hit) begin
                        s_d.st = tgt_to_st(win);
                        if (win == TG_FINAL) s_d.trig = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.trig <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.st;
    assign trig_o  = s_q.trig;

endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk
    import dbgseq_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     arm_i,
    input logic [NCH-1:0]           match_i,
    input logic [NCH-1:0]           match_en_i,
    input logic [ST_W-1:0]          state_o,
    input logic                     trig_o,
    input logic [NSEL*CODE_W-1:0]   sel_flat
);

    a_r2_arm_enters_one: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && state_o == 3'd0) |=> (state_o == 3'd1));

    a_r2_disarm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (state_o == 3'd0 && !trig_o));

    a_r3_no_live_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && state_o != 3'd0 && state_o != 3'd4 && (match_i & match_en_i) == '0)
        |=> (state_o == $past(state_o)));

    a_r10_final_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && state_o == 3'd4) |=> (state_o == 3'd4 && trig_o));

    a_r10_trig_only_final: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (state_o == 3'd4));

    a_r11_codes_frozen_armed: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> $stable(sel_flat));

    a_r12_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

endmodule

bind dbgseq_top dbgseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .match_i    (match_i),
    .match_en_i (match_en_i),
    .state_o    (state_o),
    .trig_o     (trig_o),
    .sel_flat   (sel_q)
);

// File: tb/sim_dbgseq_top.sv
module sim_dbgseq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0;
    logic [3:0] match_i = '0;
    logic [3:0] match_en_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_page_i = '0;
    logic [1:0] wr_sel_i = '0;
    logic [3:0] wr_data_i = '0;
    logic [2:0] state_o;
    logic       trig_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [2:0] exp_st_q [$];
    logic       exp_tr_q [$];
    string      tag_q    [$];

    always #4 clk = ~clk;   // 125 MHz

    dbgseq_top u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .match_i(match_i),
        .match_en_i(match_en_i), .wr_en_i(wr_en_i), .wr_page_i(wr_page_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .state_o(state_o), .trig_o(trig_o)
    );

    task automatic push(logic [2:0] st, logic tr, string tag);
        exp_st_q.push_back(st);
        exp_tr_q.push_back(tr);
        tag_q.push_back(tag);
    endtask

    // one cycle of sequencer stimulus
    task automatic cyc(logic arm, logic [3:0] m, logic [3:0] en,
                       logic [2:0] st, logic tr, string tag);
        @(negedge clk);
        arm_i = arm; match_i = m; match_en_i = en; wr_en_i = 1'b0;
        push(st, tr, tag);
    endtask

    // one cycle carrying a select-code write
    task automatic wr(logic [1:0] page, logic [1:0] sel, logic [3:0] data,
                      logic arm, logic [2:0] st, logic tr, string tag);
        @(negedge clk);
        arm_i = arm; match_i = '0; match_en_i = '0;
        wr_en_i = 1'b1; wr_page_i = page; wr_sel_i = sel; wr_data_i = data;
        push(st, tr, tag);
    endtask

    // monitor: compare one expected item per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_st_q.size() > 0) begin
                logic [2:0] es;
                logic       et;
                string      tg;
                es = exp_st_q.pop_front();
                et = exp_tr_q.pop_front();
                tg = tag_q.pop_front();
                n_chk++;
                if (state_o !== es || trig_o !== et) begin
                    n_bad++;
                    $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b",
                             tg, state_o, trig_o, es, et);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_chk++;
        if (state_o !== 3'd0 || trig_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: state=%0d trig=%0b expected state=0 trig=0", state_o, trig_o);
        end

        // R1/R7: reset codes are reserved
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm enters State1");
        cyc(1, 4'hF, 4'hF, 3'd1, 0, "R1 reset code holds State1");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm to idle");

        // load codes: S1=0101, S2=0010, S3=0011
        wr(2'b01, 2'd0, 4'b0101, 0, 3'd0, 0, "R11 write S1");
        wr(2'b01, 2'd1, 4'b0010, 0, 3'd0, 0, "R11 write S2");
        wr(2'b01, 2'd2, 4'b0011, 0, 3'd0, 0, "R11 write S3");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'b0011, 4'hF, 3'd2, 0, "R8 m0 beats m1");
        cyc(1, 4'b0100, 4'b1011, 3'd2, 0, "R3 disabled m2 ignored");
        cyc(1, 4'b0001, 4'hF, 3'd2, 0, "R5 m0 no effect under 0010");
        cyc(1, 4'b0100, 4'hF, 3'd3, 0, "R5 m2 to State3");
        cyc(1, 4'b1000, 4'hF, 3'd4, 1, "R6 m3 to Final");
        cyc(1, 4'hF, 4'hF, 3'd4, 1, "R10 Final sticky");
        cyc(0, 4'hF, 4'hF, 3'd0, 0, "R2 disarm clears trigger");
        cyc(0, 4'hF, 4'hF, 3'd0, 0, "R2 idle ignores matches");

        // final beats lower channel: S1=0001, S2=0101
        wr(2'b01, 2'd0, 4'b0001, 0, 3'd0, 0, "R11 write S1");
        wr(2'b01, 2'd1, 4'b0101, 0, 3'd0, 0, "R11 write S2");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'b0001, 4'hF, 3'd2, 0, "R4 m0 to State2");
        cyc(1, 4'b1010, 4'hF, 3'd4, 1, "R9 m3 Final beats m1");

        // write while armed is dropped
        wr(2'b01, 2'd0, 4'b0000, 1, 3'd4, 1, "R11 armed write");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'b0001, 4'hF, 3'd2, 0, "R11 armed write ignored");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm");

        // write on the wrong page is dropped
        wr(2'b10, 2'd0, 4'b0010, 0, 3'd0, 0, "R11 wrong page");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'b0001, 4'hF, 3'd2, 0, "R11 wrong page ignored");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm");

        // reserved code
        wr(2'b01, 2'd0, 4'b1100, 0, 3'd0, 0, "R11 write reserved");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'hF, 4'hF, 3'd1, 0, "R7 reserved all matches");
        cyc(1, 4'b0001, 4'hF, 3'd1, 0, "R7 reserved m0");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm");

        // one step per cycle: S1=0010 (m1->S3), S3=0100 (any->S1)
        wr(2'b01, 2'd0, 4'b0010, 0, 3'd0, 0, "R11 write S1");
        wr(2'b01, 2'd2, 4'b0100, 0, 3'd0, 0, "R11 write S3");
        cyc(1, 4'h0, 4'hF, 3'd1, 0, "R2 arm");
        cyc(1, 4'b0010, 4'hF, 3'd3, 0, "R4 m1 to State3");
        cyc(1, 4'b1000, 4'hF, 3'd1, 0, "R6 any to State1");
        cyc(1, 4'b0010, 4'hF, 3'd3, 0, "R12 single step");
        cyc(1, 4'b0010, 4'hF, 3'd1, 0, "R12 single step");
        cyc(1, 4'b0010, 4'hF, 3'd3, 0, "R12 single step");
        cyc(0, 4'h0, 4'h0, 3'd0, 0, "R2 disarm");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule